// File: doc/BRIEF.md
# Newton Square Root Unit

This block computes the square root of an unsigned fixed-point operand by Newton refinement. A caller waits for the ready flag to be high, presents an operand and a convergence tolerance, and pulses start. The unit latches both values and drops ready. It seeds a first guess from the position of the operand's leading one, then repeats the Newton update until the absolute change in the guess falls below the tolerance. When it stops, it drives the final guess onto the result output and raises ready in the same cycle.

The datapath has one shared multiplier/divider, two adder/subtractors, two comparators and a seed generator. A counter-style sequencer steps through six states: idle/capture, seed, divide-add, halve-subtract, compare-update and publish. Every non-idle state lasts two cycles, and registers load only in the second of the two. The division and the halving both run on the shared unit, in different states.

Top module: `nr_sqrt_unit`

## Requirements
- R1: After reset, ready is 1 and result is 0. Ready stays 1 while the unit is idle. Ready reads 0 in the cycle after a start that is sampled while ready is 1.
- R2: The operand and tolerance are registered when start is accepted. Changing the input pins while ready is 0 has no effect on the result or on the latency.
- R3: Operands and results are unsigned Q16.16, with 16 fraction bits. For a nonzero operand whose leading one is at bit p, the seed guess is 2^floor((p-16)/2) in Q16.16, that is, bit 16+floor((p-16)/2) set.
- R4: Each iteration computes q = floor(operand*2^16 / g), s = g + q, g' = floor(s/2) (a shift right by one), and d = g' - g, in that order.
- R5: A negative d is negated as 0 - d before the test. The loop exits when |d| < tolerance, whether d is positive or negative.
- R6: g' replaces g in every iteration, including the last one. The published result is g' from the final iteration.
- R7: With n iterations, ready is 0 for exactly 4 + 6n cycles. Ready is 1 again at the (4+6n)-th rising edge after the accepting edge.
- R8: Every non-idle state lasts two cycles, and the working registers load only in the second cycle of a state.
- R9: The result output changes only at the edge where ready rises, and it holds its value otherwise.
- R10: An operand of 0 runs no iteration. The unit returns 0 after 4 cycles with ready low.
- R11: At most 32 iterations run. When the tolerance is never met, the 32nd iteration ends the computation, with latency 196.
- R12: A start pulse while ready is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (accepted only while ready is 1) |
| operand | input | 32 | Unsigned Q16.16 radicand |
| tol | input | 32 | Unsigned Q16.16 convergence tolerance |
| result | output | 32 | Unsigned Q16.16 square root |
| ready | output | 1 | High when idle and when the result is valid |

## Verification
The bench uses two seeds to check the seed and the order of the update. For operand 4.0 the seed is already exact. For operand 2.0 with a huge tolerance, exactly one step runs and the expected result is 1.5. A design that misplaced the seed or reordered the update would publish a different value, or take a different number of iterations. A zero tolerance forces the 32-iteration cap, so a missing cap hangs the run and an off-by-one cap shifts the latency by six cycles. The bench also pokes new operand values and stray start pulses mid-run, which exposes any datapath that reads the live pins. Tiny, maximum and negative-difference operands exercise the absolute-value path and the width limits.

// File: rtl/nr_sqrt_pkg.sv
package nr_sqrt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SEED   = 3'd1,
        ST_DIVADD = 3'd2,
        ST_HALVE  = 3'd3,
        ST_CMP    = 3'd4,
        ST_OUT    = 3'd5
    } nr_state_e;

    typedef enum logic {
        MD_DIV  = 1'b0,
        MD_HALF = 1'b1
    } md_op_e;

    typedef enum logic {
        AS_ADD = 1'b0,
        AS_SUB = 1'b1
    } as_op_e;

    // bit index of the seed: frac + floor((msb - frac) / 2)
    function automatic int seed_shift(input int msb, input int frac);
        return frac + ((msb - frac) >>> 1);
    endfunction

endpackage

// File: rtl/nr_seq.sv
module nr_seq
    import nr_sqrt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  logic      skip,
    input  logic      exit_loop,
    output nr_state_e st,
    output logic      ph
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            ph <= 1'b0;
        end else if (st == ST_IDLE) begin
            ph <= 1'b0;
            if (go) st <= ST_SEED;
        end else if (!ph) begin
            ph <= 1'b1;
        end else begin
            ph <= 1'b0;
            unique case (st)
                ST_SEED:   st <= skip ? ST_OUT : ST_DIVADD;
                ST_DIVADD: st <= nr_state_e'(st + 3'd1);
                ST_HALVE:  st <= nr_state_e'(st + 3'd1);
                ST_CMP:    st <= exit_loop ? ST_OUT : ST_DIVADD;
                default:   st <= ST_IDLE;
            endcase
        end
    end

    AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> (ph != $past(ph))) else $error("phase stuck"); // R8

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (st <= ST_OUT)) else $error("illegal state"); // R8

endmodule

// File: rtl/nr_muldiv.sv
module nr_muldiv
    import nr_sqrt_pkg::*;
#(
    parameter int NW = 48,
    parameter int W  = 32
) (
    input  md_op_e          op,
    input  logic [NW-1:0]   a,
    input  logic [W-1:0]    b,
    output logic [NW-1:0]   y
);

    always_comb begin
        if (op == MD_HALF)
            y = $unsigned($signed(a) >>> 1);
        else if (b == '0)
            y = '1;
        else
            y = a / NW'(b);
    end

endmodule

// File: rtl/nr_addsub.sv
module nr_addsub
    import nr_sqrt_pkg::*;
#(
    parameter int AW = 34
) (
    input  as_op_e                 op,
    input  logic signed [AW-1:0]   a,
    input  logic signed [AW-1:0]   b,
    output logic signed [AW-1:0]   y
);

    always_comb y = (op == AS_SUB) ? (a - b) : (a + b);

endmodule

// File: rtl/nr_cmp.sv
module nr_cmp #(
    parameter int AW = 34
) (
    input  logic signed [AW-1:0] a,
    input  logic signed [AW-1:0] b,
    output logic                 lt
);

    always_comb lt = (a < b);

endmodule

// File: rtl/nr_sqrt_unit.sv
module nr_sqrt_unit
    import nr_sqrt_pkg::*;
#(
    parameter int W   = 32,
    parameter int F   = 16,
    parameter int CAP = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] tol,
    output logic [W-1:0] result,
    output logic         ready
);

    localparam int NW = W + F;
    localparam int AW = W + 2;
    localparam int IW = $clog2(CAP + 1);

    nr_state_e st;
    logic      ph;

    logic [W-1:0]           x_q, tol_q, guess_q, newg_q, res_q;
    logic signed [AW-1:0]   sum_q, diff_q;
    logic [IW-1:0]          iter_q;
    logic                   rdy_q;

    logic go, skip, exit_loop, neg, conv;
    logic [W-1:0] seed_v;

    md_op_e               md_op;
    logic [NW-1:0]        md_a, md_y;
    logic signed [AW-1:0] as1_y, as2_a, as2_b, as2_y, absd;

    assign go   = start && rdy_q && (st == ST_IDLE);
    assign skip = (x_q == '0);

    nr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .skip      (skip),
        .exit_loop (exit_loop),
        .st        (st),
        .ph        (ph)
    );

    // seed: one bit set, chosen by the leading-one position
    always_comb begin
        int msb;
        msb = 0;
        for (int i = 0; i < W; i++)
            if (x_q[i]) msb = i;
        seed_v = W'(1) << seed_shift(msb, F);
    end

    // shared multiplier/divider: divide in DIVADD, halve in HALVE
    always_comb begin
        if (st == ST_HALVE) begin
            md_op = MD_HALF;
            md_a  = NW'($unsigned(sum_q));
        end else begin
            md_op = MD_DIV;
            md_a  = {x_q, {F{1'b0}}};
        end
    end

    nr_muldiv #(.NW(NW), .W(W)) u_md (
        .op (md_op),
        .a  (md_a),
        .b  (guess_q),
        .y  (md_y)
    );

    // adder 1: guess + quotient
    nr_addsub #(.AW(AW)) u_as1 (
        .op (AS_ADD),
        .a  ($signed({2'b00, guess_q})),
        .b  ($signed(md_y[AW-1:0])),
        .y  (as1_y)
    );

    // adder 2: new - old in HALVE, 0 - diff in CMP
    always_comb begin
        if (st == ST_CMP) begin
            as2_a = '0;
            as2_b = diff_q;
        end else begin
            as2_a = $signed(md_y[AW-1:0]);
            as2_b = $signed({2'b00, guess_q});
        end
    end

    nr_addsub #(.AW(AW)) u_as2 (
        .op (AS_SUB),
        .a  (as2_a),
        .b  (as2_b),
        .y  (as2_y)
    );

    nr_cmp #(.AW(AW)) u_cmp_sign (
        .a  (diff_q),
        .b  ('0),
        .lt (neg)
    );

    assign absd = neg ? as2_y : diff_q;

    nr_cmp #(.AW(AW)) u_cmp_conv (
        .a  (absd),
        .b  ($signed({2'b00, tol_q})),
        .lt (conv)
    );

    assign exit_loop = conv || (iter_q == IW'(CAP - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q     <= '0;
            tol_q   <= '0;
            guess_q <= '0;
            newg_q  <= '0;
            sum_q   <= '0;
            diff_q  <= '0;
            iter_q  <= '0;
            res_q   <= '0;
            rdy_q   <= 1'b1;
        end else begin
            if (go) begin
                x_q    <= operand;
                tol_q  <= tol;
                iter_q <= '0;
                rdy_q  <= 1'b0;
            end
            if (ph) begin
                unique case (st)
                    ST_SEED:   guess_q <= skip ? '0 : seed_v;
                    ST_DIVADD: sum_q   <= as1_y;
                    ST_HALVE: begin
                        newg_q <= md_y[W-1:0];
                        diff_q <= as2_y;
                    end
                    ST_CMP: begin
                        guess_q <= newg_q;
                        iter_q  <= iter_q + IW'(1);
                    end
                    ST_OUT: begin
                        res_q <= guess_q;
                        rdy_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign result = res_q;
    assign ready  = rdy_q;

    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        (start && rdy_q) |=> !rdy_q) else $error("ready kept"); // R1

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (rst)
        !rdy_q |=> ($stable(x_q) && $stable(tol_q))) else $error("capture moved"); // R12

    AST_RESULT_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        !$stable(res_q) |-> $rose(rdy_q)) else $error("result moved alone"); // R9

    AST_LOAD_ON_PHASE: assert property (@(posedge clk) disable iff (rst)
        !$stable(guess_q) |-> $past(ph)) else $error("load off phase"); // R8

    AST_ITER_CAP: assert property (@(posedge clk) disable iff (rst)
        (iter_q <= IW'(CAP))) else $error("iteration cap exceeded"); // R11

    AST_QUOT_FITS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DIVADD) |-> (md_y[NW-1:AW] == '0)) else $error("quotient overflow"); // R4

    AST_HALF_FITS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HALVE) |-> (md_y[NW-1:W] == '0)) else $error("guess overflow"); // R4

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DIVADD) |-> (guess_q != '0)) else $error("divide by zero"); // R3

endmodule

// File: tb/test_nr_sqrt_unit.sv
`timescale 1ns/1ps
module test_nr_sqrt_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [31:0] tol = '0;
    logic [31:0] result;
    logic        ready;

    int errors = 0;
    int checks = 0;
    bit live = 1'b0;

    always #10 clk = ~clk;

    nr_sqrt_unit i_nr_sqrt_unit (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .operand (operand),
        .tol     (tol),
        .result  (result),
        .ready   (ready)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: Newton loop on wide integers
    function automatic void ref_sqrt(input logic [31:0] x, input logic [31:0] t,
                                     output logic [31:0] r, output int n);
        longint num, g, q, ng, d;
        int msb, sh;
        n = 0;
        r = '0;
        if (x == 0) return;
        msb = 0;
        for (int i = 0; i < 32; i++) if (x[i]) msb = i;
        sh = (msb - 16) >>> 1;
        g = longint'(1) << (16 + sh);
        num = longint'(x) << 16;
        for (int it = 1; it <= 32; it++) begin
            q  = num / g;
            ng = (g + q) / 2;
            d  = ng - g;
            if (d < 0) d = -d;
            g = ng;
            n = it;
            if (d < longint'(t)) break;
        end
        r = g[31:0];
    endfunction

    // cycle model of ready/result
    logic        rdy_m;
    logic [31:0] res_m, pend_m;
    int          cnt_m;

    always @(posedge clk) begin
        if (rst) begin
            rdy_m <= 1'b1;
            res_m <= '0;
            cnt_m <= 0;
        end else if (rdy_m) begin
            if (start) begin
                logic [31:0] r;
                int n;
                ref_sqrt(operand, tol, r, n);
                pend_m <= r;
                cnt_m  <= 4 + 6 * n - 1;
                rdy_m  <= 1'b0;
            end
        end else if (cnt_m == 0) begin
            rdy_m <= 1'b1;
            res_m <= pend_m;
        end else begin
            cnt_m <= cnt_m - 1;
        end
    end

    always @(negedge clk) begin
        if (live) begin
            check("R1/R7/R8 ready per cycle", longint'(ready), longint'(rdy_m));
            check("R9 result per cycle", longint'(result), longint'(res_m));
        end
    end

    // run one operation; optionally poke pins at a given busy cycle
    task automatic run_op(input logic [31:0] x, input logic [31:0] t,
                          input int poke_at, input logic [31:0] px,
                          input logic [31:0] pt, input logic pstart,
                          output logic [31:0] r, output int lat);
        @(negedge clk);
        while (!ready) @(negedge clk);
        operand = x;
        tol     = t;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!ready) begin
            if (lat == poke_at) begin
                operand = px;
                tol     = pt;
                start   = pstart;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        r = result;
    endtask

    task automatic run_cmp(input string tag, input logic [31:0] x, input logic [31:0] t);
        logic [31:0] r, er;
        int lat, n;
        ref_sqrt(x, t, er, n);
        run_op(x, t, -1, '0, '0, 1'b0, r, lat);
        check({tag, " result"}, longint'(r), longint'(er));
        check({tag, " latency R7"}, longint'(lat), longint'(4 + 6 * n));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] r, er;
        int lat, n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        live = 1'b1;
        check("R1 reset ready", longint'(ready), 1);
        check("R1 reset result", longint'(result), 0);
        repeat (3) @(negedge clk);
        check("R1 idle ready", longint'(ready), 1);

        // operand 4.0: seed 2.0 exact, one iteration, d = 0
        run_op(32'h0004_0000, 32'h1, -1, '0, '0, 1'b0, r, lat);
        check("R3/R4/R6 sqrt(4.0)", longint'(r), 32'h0002_0000);
        check("R7 one-iteration latency", longint'(lat), 10);

        // operand 2.0: seed 1.0, one step gives 1.5 with positive d
        run_op(32'h0002_0000, 32'hFFFF_FFFF, -1, '0, '0, 1'b0, r, lat);
        check("R3/R4/R5 first step of sqrt(2.0)", longint'(r), 32'h0001_8000);
        check("R5 huge tolerance exits after one", longint'(lat), 10);

        // zero operand
        run_op(32'h0, 32'h5, -1, '0, '0, 1'b0, r, lat);
        check("R10 zero result", longint'(r), 0);
        check("R10 zero latency", longint'(lat), 4);

        // converged values with negative differences
        run_cmp("R5/R6 sqrt(9.0)", 32'h0009_0000, 32'h10);
        check("R5 sqrt(9.0) near 3.0", longint'(result >= 32'h0002_FFF0 && result <= 32'h0003_0010), 1);
        run_cmp("R4/R5 sqrt(2.0) tight", 32'h0002_0000, 32'h2);
        run_cmp("R3 tiny operand", 32'h0000_0001, 32'h1);
        run_cmp("R3 max operand", 32'hFFFF_FFFF, 32'h4);
        run_cmp("R3 operand 3.0", 32'h0003_0000, 32'h1);
        run_cmp("R4 odd operand", 32'h7B5A_1234, 32'h8);

        // zero tolerance: cap at 32 iterations
        run_op(32'h0002_0000, 32'h0, -1, '0, '0, 1'b0, r, lat);
        ref_sqrt(32'h0002_0000, 32'h0, er, n);
        check("R11 capped latency", longint'(lat), 196);
        check("R11 capped result", longint'(r), longint'(er));

        // pins changed mid-run
        ref_sqrt(32'h0064_0000, 32'h20, er, n);
        run_op(32'h0064_0000, 32'h20, 3, 32'h0001_0000, 32'hFFFF_FFFF, 1'b0, r, lat);
        check("R2 pins ignored result", longint'(r), longint'(er));
        check("R2 pins ignored latency", longint'(lat), longint'(4 + 6 * n));

        // stray start mid-run
        ref_sqrt(32'h0019_0000, 32'h8, er, n);
        run_op(32'h0019_0000, 32'h8, 7, 32'h0000_0000, 32'h1, 1'b1, r, lat);
        check("R12 stray start result", longint'(r), longint'(er));
        check("R12 stray start latency", longint'(lat), longint'(4 + 6 * n));
        repeat (2) @(negedge clk);
        check("R12 no restart after stray start", longint'(ready), 1);

        // start held across ready rise: back-to-back accept
        operand = 32'h0010_0000;
        tol     = 32'h4;
        start   = 1'b1;
        repeat (40) @(negedge clk);
        start = 1'b0;
        while (!ready) @(negedge clk);
        ref_sqrt(32'h0010_0000, 32'h4, er, n);
        check("R1/R6 back-to-back result", longint'(result), longint'(er));

        repeat (4) @(negedge clk);
        live = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule